// File: doc/BRIEF.md
# Four-Stage Instruction Sequencer

This block is the control and datapath sequencer of a small 32-bit, little-endian, load/store processor core. Instructions run one at a time and never overlap. Each implemented instruction passes through the same four stages, one clock cycle each. Fetch puts the instruction address on the bus. Decode captures the memory word one cycle later. Execute computes the result and the new flags into holding registers. Retire commits the held values and advances the program address by four bytes. The block has two further states: a reset state, and a halt state that only reset can leave.

The instruction set covered here has four kinds of instruction:
- load of a 16-bit immediate into either half of a register;
- register/register and register/immediate ALU operations at word, half-word or byte width;
- NOP;
- HALT.

The ALU is a separate module instantiated inside the block. The register file holds 16 registers, and register 0 always reads as zero. The block reports its stage code, its flags and one selected register so that a test harness or a board can watch it.

Top module: `seq_core`

## Requirements
- R1: While rst_ni is low, stage_o is 0, addr_valid_o is 0, flags_o is 0 and every register reads 0. At the first rising edge with rst_ni high, the block moves to fetch.
- R2: Stage codes are fetch=1, decode=2, execute=3 and retire=4. Each stage lasts one cycle. The order is fetch, decode, execute, retire, then back to fetch.
- R3: In fetch, decode and execute, addr_o holds the address of the current instruction and addr_valid_o is 1. The memory answers one cycle after the address appears, and the block samples data_i at the end of decode.
- R4: In retire, reset and halt, addr_valid_o is 0.
- R5: After reset, the first instruction is fetched from address 0. After each retire, the next fetch address is the previous one plus 4.
- R6: Opcode field [31:28] selects the instruction: 0 is NOP, 1 is load-immediate, 2 is ALU, 15 is HALT, and any other value acts as NOP. Load-immediate writes imm [15:0] into register [27:24]. Bit [16]=1 selects the upper half and 0 selects the lower half. The other half of the register is kept, and the flags are left unchanged.
- R7: An ALU instruction has these fields:
  - destination [27:24], source A [23:20], source B [19:16];
  - bit [15]=1 replaces source B with the zero-extended imm [7:0];
  - function [14:12]: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 pass B. Shift amounts come from B[4:0];
  - width [11:10]: 1 is 16-bit, 2 is 8-bit, and 0 or 3 is 32-bit.

  Both operands are masked to the width, and the result is zero-extended.
- R8: flags_o holds {V,C,N,Z} in bits [3:0]. The bits are:
  - Z: the width-masked result is 0;
  - N: the result's top bit at the operation width;
  - C: carry out of an add, or borrow of a subtract;
  - V: signed overflow of an add or subtract.

  C and V are 0 for all other functions. Only ALU instructions change the flags, and they do so at retire.
- R9: An instruction whose source register is also its destination reads the old value and writes the new one.
- R10: Writes to register 0 are discarded, and register 0 reads 0 both as an operand and on dbg_reg_o.
- R11: HALT goes from execute to the halt stage, code 5. The block stays there with no further fetches and no register change until reset.
- R12: NOP changes nothing except the fetch address.
- R13: dbg_reg_o shows, without a clock delay, the register selected by dbg_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_o | output | 32 | Instruction byte address |
| addr_valid_o | output | 1 | Address bus is driven |
| data_i | input | 32 | Instruction word from memory, one cycle after the address |
| dbg_sel_i | input | 4 | Register index for the debug output |
| stage_o | output | 3 | Current stage code |
| flags_o | output | 4 | {V,C,N,Z} |
| dbg_reg_o | output | 32 | Selected register value |

## Verification
On every cycle, the assertions check four things:
- the stage order;
- the release of the address bus outside fetch, decode and execute;
- the address staying stable from fetch to decode, and stepping by 4 across retire;
- the halt stage holding, the flags changing only after retire, and register 0 reading zero.

The arithmetic needs the bench's scenarios. These cover results and flags for every function at every width, a set of operand pairs in both register and immediate form, and the half-preserving immediate load. The bench also covers same-register source and destination, discarded writes to register 0, and undefined opcodes acting as NOP.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int XLEN = 32;
  parameter int NREG = 16;
  localparam int RW        = $clog2(NREG);
  localparam int SHW       = $clog2(XLEN);
  localparam int ADDR_STEP = XLEN / 8;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_RETIRE = 3'd4,
    ST_HALT   = 3'd5
  } stage_e;

  typedef enum logic [1:0] {K_NOP, K_LDI, K_ALU, K_HALT} kind_e;

  typedef enum logic [2:0] {
    F_ADD = 3'd0, F_SUB = 3'd1, F_AND = 3'd2, F_OR = 3'd3,
    F_XOR = 3'd4, F_SHL = 3'd5, F_SHR = 3'd6, F_PASS = 3'd7
  } func_e;

  typedef enum logic [1:0] {W_WORD = 2'd0, W_HALF = 2'd1, W_BYTE = 2'd2, W_WORD2 = 2'd3} width_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

  typedef struct packed {
    kind_e         kind;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs_a;
    logic [RW-1:0] rs_b;
    logic          use_imm;
    func_e         func;
    width_e        width;
    logic [7:0]    imm8;
    logic          ldi_hi;
    logic [15:0]   imm16;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [XLEN-1:0] ir_i,
  output dec_t            dec_o
);
  logic [3:0] opc;
  assign opc = ir_i[31:28];

  always_comb begin
    unique case (opc)
      4'h1:    dec_o.kind = K_LDI;
      4'h2:    dec_o.kind = K_ALU;
      4'hF:    dec_o.kind = K_HALT;
      default: dec_o.kind = K_NOP;
    endcase
    dec_o.rd      = ir_i[24 +: RW];
    // load-immediate reads its own destination to keep the other half
    dec_o.rs_a    = (dec_o.kind == K_LDI) ? ir_i[24 +: RW] : ir_i[20 +: RW];
    dec_o.rs_b    = ir_i[16 +: RW];
    dec_o.use_imm = ir_i[15];
    dec_o.func    = func_e'(ir_i[14:12]);
    dec_o.width   = width_e'(ir_i[11:10]);
    dec_o.imm8    = ir_i[7:0];
    dec_o.ldi_hi  = ir_i[16];
    dec_o.imm16   = ir_i[15:0];
  end
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  func_e           func_i,
  input  width_e          width_i,
  output logic [XLEN-1:0] res_o,
  output flags_t          flags_o
);
  logic [XLEN-1:0] mask, am, bm, raw, r;
  logic [XLEN:0]   sum, dif;
  int unsigned     sb;

  always_comb begin
    unique case (width_i)
      W_HALF:  begin mask = XLEN'(32'h0000_FFFF); sb = 15; end
      W_BYTE:  begin mask = XLEN'(32'h0000_00FF); sb = 7;  end
      default: begin mask = '1;                   sb = XLEN - 1; end
    endcase
    am  = a_i & mask;
    bm  = b_i & mask;
    sum = {1'b0, am} + {1'b0, bm};
    dif = {1'b0, am} - {1'b0, bm};
    unique case (func_i)
      F_ADD:   raw = sum[XLEN-1:0];
      F_SUB:   raw = dif[XLEN-1:0];
      F_AND:   raw = am & bm;
      F_OR:    raw = am | bm;
      F_XOR:   raw = am ^ bm;
      F_SHL:   raw = am << bm[SHW-1:0];
      F_SHR:   raw = am >> bm[SHW-1:0];
      default: raw = bm;
    endcase
    r = raw & mask;
    flags_o.z = (r == '0);
    flags_o.n = r[sb];
    flags_o.c = 1'b0;
    flags_o.v = 1'b0;
    if (func_i == F_ADD) begin
      flags_o.c = |(sum & ~{1'b0, mask});
      flags_o.v = (am[sb] == bm[sb]) && (r[sb] != am[sb]);
    end else if (func_i == F_SUB) begin
      flags_o.c = dif[XLEN];
      flags_o.v = (am[sb] != bm[sb]) && (r[sb] != am[sb]);
    end
    res_o = r;
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [RW-1:0]   ra_i,
  input  logic [RW-1:0]   rb_i,
  input  logic [RW-1:0]   rc_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  output logic [XLEN-1:0] c_o
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs_q[i] <= '0;
        else if (we_i && wa_i == RW'(i))    regs_q[i] <= wd_i;
      end
    end
  end

  assign a_o = regs_q[ra_i];
  assign b_o = regs_q[rb_i];
  assign c_o = regs_q[rc_i];
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] addr_o,
  output logic        addr_valid_o,
  input  logic [31:0] data_i,
  input  logic [3:0]  dbg_sel_i,
  output logic [2:0]  stage_o,
  output logic [3:0]  flags_o,
  output logic [31:0] dbg_reg_o
);
  stage_e          state_q, state_d;
  logic [XLEN-1:0] next_addr_q, cur_addr_q, ir_q;
  logic [XLEN-1:0] hold_val_q;
  logic            hold_we_q, hold_fwe_q;
  logic [RW-1:0]   hold_rd_q;
  flags_t          hold_flags_q, flags_q;

  dec_t            dec;
  logic [XLEN-1:0] a_val, b_val, opb, alu_res, ldi_val, exec_val;
  flags_t          alu_flags;

  seq_decode u_dec (.ir_i(ir_q), .dec_o(dec));

  seq_regfile u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (state_q == ST_RETIRE && hold_we_q),
    .wa_i  (hold_rd_q),
    .wd_i  (hold_val_q),
    .ra_i  (dec.rs_a),
    .rb_i  (dec.rs_b),
    .rc_i  (dbg_sel_i[RW-1:0]),
    .a_o   (a_val),
    .b_o   (b_val),
    .c_o   (dbg_reg_o)
  );

  assign opb = dec.use_imm ? XLEN'(dec.imm8) : b_val;

  seq_alu u_alu (
    .a_i    (a_val),
    .b_i    (opb),
    .func_i (dec.func),
    .width_i(dec.width),
    .res_o  (alu_res),
    .flags_o(alu_flags)
  );

  assign ldi_val  = dec.ldi_hi ? {dec.imm16, a_val[15:0]} : {a_val[XLEN-1:16], dec.imm16};
  assign exec_val = (dec.kind == K_LDI) ? ldi_val : alu_res;

  always_comb begin
    unique case (state_q)
      ST_RESET:  state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = (dec.kind == K_HALT) ? ST_HALT : ST_RETIRE;
      ST_RETIRE: state_d = ST_FETCH;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RESET;
      next_addr_q  <= RESET_ADDR;
      cur_addr_q   <= RESET_ADDR;
      ir_q         <= '0;
      hold_val_q   <= '0;
      hold_we_q    <= 1'b0;
      hold_fwe_q   <= 1'b0;
      hold_rd_q    <= '0;
      hold_flags_q <= '0;
      flags_q      <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_FETCH:  cur_addr_q <= next_addr_q;
        ST_DECODE: ir_q <= data_i;
        ST_EXEC: begin
          hold_val_q   <= exec_val;
          hold_rd_q    <= dec.rd;
          hold_we_q    <= (dec.kind == K_LDI) || (dec.kind == K_ALU);
          hold_fwe_q   <= (dec.kind == K_ALU);
          hold_flags_q <= alu_flags;
        end
        ST_RETIRE: begin
          if (hold_fwe_q) flags_q <= hold_flags_q;
          next_addr_q <= next_addr_q + XLEN'(ADDR_STEP);
        end
        default: ;
      endcase
    end
  end

  assign addr_o       = (state_q == ST_FETCH) ? next_addr_q : cur_addr_q;
  assign addr_valid_o = (state_q == ST_FETCH) || (state_q == ST_DECODE) || (state_q == ST_EXEC);
  assign stage_o      = state_q;
  assign flags_o      = flags_q;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] addr_o,
  input logic        addr_valid_o,
  input logic [3:0]  dbg_sel_i,
  input logic [2:0]  stage_o,
  input logic [3:0]  flags_o,
  input logic [31:0] dbg_reg_o
);
  p_order_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd1 |=> stage_o == 3'd2);
  p_order_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd2 |=> stage_o == 3'd3);
  p_order_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd3 |=> (stage_o == 3'd4 || stage_o == 3'd5));
  p_order_retire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd4 |=> stage_o == 3'd1);
  p_leave_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd0 |=> stage_o == 3'd1);
  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd2 |-> addr_valid_o && addr_o == $past(addr_o));
  p_addr_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'd0 || stage_o == 3'd4 || stage_o == 3'd5) |-> !addr_valid_o);
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'd1 && $past(stage_o) == 3'd4) |-> addr_o == $past(addr_o) + 32'd4);
  p_flags_retire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o != 3'd4 |=> $stable(flags_o));
  p_halt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd5 |=> stage_o == 3'd5);
  p_zero_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_sel_i == 4'd0 |-> dbg_reg_o == 32'd0);
endmodule

bind seq_core seq_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o),
  .dbg_sel_i   (dbg_sel_i),
  .stage_o     (stage_o),
  .flags_o     (flags_o),
  .dbg_reg_o   (dbg_reg_o)
);

// File: tb/seq_core_bench.sv
`timescale 1ns/1ps
module seq_core_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_o, data_i, dbg_reg_o;
  logic        addr_valid_o;
  logic [3:0]  dbg_sel_i = 4'd0;
  logic [2:0]  stage_o;
  logic [3:0]  flags_o;

  logic [31:0] mem [64];
  int          n_chk = 0, n_err = 0, cyc = 0, pc = 0;
  logic [31:0] last_addr;
  localparam logic [31:0] HALT_W = 32'hF000_0000;
  localparam logic [31:0] NOP_W  = 32'h0000_0000;

  always #10 clk = ~clk;

  seq_core u_seq_core (
    .clk_i(clk), .rst_ni(rst_ni), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .data_i(data_i), .dbg_sel_i(dbg_sel_i), .stage_o(stage_o), .flags_o(flags_o),
    .dbg_reg_o(dbg_reg_o)
  );

  always @(posedge clk) data_i <= mem[addr_o[7:2]];
  always @(negedge clk) if (addr_valid_o) last_addr <= addr_o;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_ldi(input int rd, input bit hi, input logic [15:0] imm);
    return {4'h1, 4'(rd), 7'd0, hi, imm};
  endfunction

  function automatic logic [31:0] enc_alu(input int rd, input int ra, input int rb, input bit ui,
                                          input int fn, input int wd, input logic [7:0] imm);
    return {4'h2, 4'(rd), 4'(ra), 4'(rb), ui, 3'(fn), 2'(wd), 2'b00, imm};
  endfunction

  // {V,C,N,Z, result} from the arithmetic definitions of R7 and R8
  function automatic logic [35:0] model(input int fn, input int wd, input logic [31:0] a,
                                        input logic [31:0] b);
    longint unsigned m, x, y, r, top;
    logic c, v, sa, sbb, sr;
    int bits;
    bits = (wd == 1) ? 16 : (wd == 2) ? 8 : 32;
    m = (64'd1 << bits) - 1;
    top = 64'd1 << (bits - 1);
    x = a & m; y = b & m; c = 0; v = 0;
    case (fn)
      0: begin r = x + y; c = (r > m); end
      1: begin r = x - y; c = (x < y); end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: r = x << (y % 32);
      6: r = x >> (y % 32);
      default: r = y;
    endcase
    r = r & m;
    sa = (x & top) != 0; sbb = (y & top) != 0; sr = (r & top) != 0;
    if (fn == 0) v = (sa == sbb) && (sr != sa);
    if (fn == 1) v = (sa != sbb) && (sr != sa);
    return {v, c, sr, (r == 0), r[31:0]};
  endfunction

  task automatic new_prog();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = HALT_W;
    pc = 0;
    @(negedge clk);
  endtask

  task automatic emit(input logic [31:0] w);
    mem[pc] = w;
    pc++;
  endtask

  task automatic run_prog(input string req);
    int n;
    rst_ni = 1'b1;
    n = 0;
    while (stage_o != 3'd5 && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({req, " halted"}, 32'(stage_o), 32'd5);
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    dbg_sel_i = 4'(idx);
    #1 v = dbg_reg_o;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_err++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  logic [31:0] pa [7];
  logic [31:0] pb [7];

  initial begin
    logic [31:0] v, bexp;
    logic [35:0] e;
    for (int i = 0; i < 64; i++) mem[i] = HALT_W;
    pa[0] = 32'h0;        pb[0] = 32'h0;
    pa[1] = 32'h1;        pb[1] = 32'h1;
    pa[2] = 32'hFFFF_FFFF; pb[2] = 32'h1;
    pa[3] = 32'h8000_8080; pb[3] = 32'h8000_8080;
    pa[4] = 32'h7FFF_7F7F; pb[4] = 32'h0001_0101;
    pa[5] = 32'h1234_5678; pb[5] = 32'h9ABC_DEF3;
    pa[6] = 32'h0000_0001; pb[6] = 32'hFFFF_FFFF;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 stage in reset", 32'(stage_o), 32'd0);
    check("R1 addr_valid in reset", 32'(addr_valid_o), 32'd0);
    check("R1 flags in reset", 32'(flags_o), 32'd0);
    for (int r = 0; r < 16; r++) begin
      rd_reg(r, v);
      check("R1 R13 register cleared", v, 32'd0);
    end

    // R2 R3 R4 R5: cycle-by-cycle stage and bus timing
    new_prog();
    emit(enc_ldi(1, 0, 16'h00AB));
    emit(NOP_W);
    emit(HALT_W);
    rst_ni = 1'b1;
    #1 check("R1 stage right after release", 32'(stage_o), 32'd0);
    for (int k = 1; k <= 16; k++) begin
      int ins, ph, st;
      @(negedge clk);
      ins = (k - 1) / 4; ph = (k - 1) % 4;
      if (ins < 2) st = ph + 1;
      else if (ins == 2) st = (ph < 3) ? ph + 1 : 5;
      else st = 5;
      check("R2 R11 stage sequence", 32'(stage_o), 32'(st));
      check("R3 R4 addr_valid", 32'(addr_valid_o), 32'(st >= 1 && st <= 3));
      if (st >= 1 && st <= 3) check("R3 R5 fetch address", addr_o, 32'(4 * ins));
    end
    rd_reg(1, v);
    check("R3 R6 word captured at decode", v, 32'h0000_00AB);

    // R7 R8: sweep of functions, widths, operand pairs, register and immediate forms
    for (int fn = 0; fn < 8; fn++)
      for (int wd = 0; wd < 4; wd++)
        for (int p = 0; p < 7; p++)
          for (int ui = 0; ui < 2; ui++) begin
            new_prog();
            emit(enc_ldi(1, 0, pa[p][15:0]));
            emit(enc_ldi(1, 1, pa[p][31:16]));
            emit(enc_ldi(2, 0, pb[p][15:0]));
            emit(enc_ldi(2, 1, pb[p][31:16]));
            emit(enc_alu(3, 1, 2, ui[0], fn, wd, pb[p][7:0]));
            run_prog("R7");
            bexp = ui[0] ? {24'd0, pb[p][7:0]} : pb[p];
            e = model(fn, wd, pa[p], bexp);
            rd_reg(3, v);
            check($sformatf("R7 result fn%0d w%0d p%0d i%0d", fn, wd, p, ui), v, e[31:0]);
            check($sformatf("R8 flags fn%0d w%0d p%0d i%0d", fn, wd, p, ui),
                  32'(flags_o), 32'(e[35:32]));
          end

    // R6 R8: half-preserving immediate loads leave flags alone
    new_prog();
    emit(enc_alu(4, 0, 0, 0, 1, 0, 8'd0));
    emit(enc_ldi(2, 1, 16'hDEAD));
    emit(enc_ldi(2, 0, 16'hBEEF));
    emit(enc_ldi(2, 1, 16'h1234));
    run_prog("R6");
    rd_reg(2, v);
    check("R6 load-immediate keeps other half", v, 32'h1234_BEEF);
    check("R6 R8 flags unchanged by load-immediate", 32'(flags_o), 32'h1);

    // R9: source equals destination
    new_prog();
    emit(enc_ldi(1, 0, 16'd5));
    emit(enc_alu(1, 1, 1, 0, 0, 0, 8'd0));
    emit(enc_alu(1, 1, 0, 1, 1, 0, 8'd1));
    run_prog("R9");
    rd_reg(1, v);
    check("R9 same-register source and destination", v, 32'd9);

    // R10: register 0
    new_prog();
    emit(enc_ldi(0, 0, 16'h5555));
    emit(enc_alu(5, 0, 0, 1, 0, 0, 8'd3));
    emit(enc_alu(0, 5, 5, 0, 0, 0, 8'd0));
    run_prog("R10");
    rd_reg(0, v);
    check("R10 register 0 write discarded", v, 32'd0);
    rd_reg(5, v);
    check("R10 register 0 operand reads zero", v, 32'd3);

    // R12 R6 R11: NOP and undefined opcodes, then halt holds
    new_prog();
    emit(enc_ldi(6, 0, 16'd7));
    emit(NOP_W);
    emit(32'h5FFF_FFFF);
    emit(NOP_W);
    run_prog("R12");
    for (int r = 0; r < 16; r++) begin
      rd_reg(r, v);
      check($sformatf("R12 register %0d after NOPs", r), v, (r == 6) ? 32'd7 : 32'd0);
    end
    check("R12 flags after NOPs", 32'(flags_o), 32'd0);
    check("R12 HALT fetched at address 16", last_addr, 32'd16);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R11 halt holds", 32'(stage_o), 32'd5);
      check("R11 R4 bus released in halt", 32'(addr_valid_o), 32'd0);
    end
    check("R11 no fetch after halt", last_addr, 32'd16);
    rd_reg(6, v);
    check("R11 registers unchanged in halt", v, 32'd7);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule